// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line of one direct-mapped cache that sits on a shared snooping bus. It holds a tag and a two-bit state for each set. On the processor side it takes a read or write request with a line address. It reports whether the request hits, and it signals completion. On the bus side it raises read, read-for-ownership, upgrade and write-back requests. It also watches the requests that other caches put on the bus and changes its own lines to match.

The request the controller raises is worked out fresh each cycle from the current state of the addressed set. Because of this, a snoop that changes a line while a request is waiting changes the request as well. An upgrade that loses its copy turns into a read-for-ownership. A dirty victim that a snoop has already cleaned is dropped without a write-back. Data storage, memory and bus arbitration live outside the block. The bus never shows a snoop in the same cycle as this cache's own acknowledge.

Top module: `coh_ctrl_top`

## Requirements
- R1: After reset every line is Invalid (state code I=0, S=1, E=2, M=3), so the first access to any address misses and raises a bus request.
- R2: A read miss to a clean or Invalid line requests a bus read (command 0) at the request address. In the acknowledge cycle the access completes, and the line becomes Exclusive when busShared is low and Shared when it is high.
- R3: A write miss to a clean or Invalid line requests a read-for-ownership (command 1). In the acknowledge cycle the access completes and the line becomes Modified.
- R4: A write hit on a Shared line requests an upgrade (command 2) and becomes Modified when acknowledged. If a snoop invalidates the line while the upgrade waits, the request turns into a read-for-ownership.
- R5: A write hit on an Exclusive line completes in the same cycle with no bus request, and the line becomes Modified.
- R6: A read hit in any valid state, and a write hit on a Modified line, complete in the same cycle with no bus request and leave the state unchanged.
- R7: A miss whose set holds a Modified line of another tag first requests a write-back (command 3) at the victim's address {old tag, set}. When that is acknowledged, the line becomes Invalid without completing the access, and the fill follows. Clean victims are replaced without a write-back.
- R8: A snooped read (snoop command 0) that hits a valid line raises snpShared. Hitting Modified also raises snpFlush. Modified and Exclusive lines become Shared.
- R9: A snooped read-for-ownership (snoop command 1) or invalidate (snoop command 2) that hits a valid line makes it Invalid. The read-for-ownership also raises snpFlush when the line was Modified.
- R10: When a snoop and a processor request address the same set in the same cycle, the snoop is applied. The processor request neither completes nor drives the bus in that cycle, and is served afterwards against the updated state.
- R11: Snoop command 3, and any snoop whose tag misses or whose line is Invalid, changes no state and raises neither snpShared nor snpFlush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | Processor request present; held until cpuDone |
| cpuWrite | input | 1 | Request is a write |
| cpuAddr | input | ADDR_W | Line address: tag above, set index in the low SET_W bits |
| cpuHit | output | 1 | Tag matches a valid line in the addressed set |
| cpuDone | output | 1 | Request completes in this cycle |
| busReqValid | output | 1 | Bus request raised |
| busReqCmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| busReqAddr | output | ADDR_W | Line address of the bus request |
| busAck | input | 1 | Bus has performed the raised request |
| busShared | input | 1 | Another cache holds the line (valid with busAck) |
| snpValid | input | 1 | Snooped transaction from another cache |
| snpCmd | input | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 none |
| snpAddr | input | ADDR_W | Snooped line address |
| snpShared | output | 1 | This cache holds the snooped line for a read |
| snpFlush | output | 1 | This cache must supply its dirty data |

## Verification
A processor access and a snoop can land on the same set in one cycle. The bench provokes this on purpose by driving both together. It does so on a line it holds and also during a pending upgrade, where an invalidate arrives before the acknowledge. In those cycles it expects no completion and no bus request, together with the snoop response its own state model predicts. In the following cycles it expects the request that this updated state implies: a read-for-ownership in place of the upgrade. Random traffic over four tags and four sets then mixes snoops between accesses, so that evictions, write-backs and state downgrades keep hitting lines the processor touches next.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    BUS_RD   = 2'd0,
    BUS_RDX  = 2'd1,
    BUS_UPGR = 2'd2,
    BUS_WB   = 2'd3
  } busCmd_t;

  localparam logic [1:0] SNP_RD  = 2'd0;
  localparam logic [1:0] SNP_RDX = 2'd1;
  localparam logic [1:0] SNP_INV = 2'd2;

  // strobes from the access control to the line store
  typedef struct packed {
    logic       fillEn;    // write tag and state of the processor set
    lineState_t fillState;
    logic       dropEn;    // mark the processor set Invalid
  } ctrlStrobe_t;
endpackage

// File: rtl/coh_line_store.sv
`timescale 1ns/1ps
module coh_line_store
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SET_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  ctrlStrobe_t       strb,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output lineState_t        cpuSt,
  output logic [ADDR_W-SET_W-1:0] cpuTagQ,
  output logic              cpuHit,
  output logic              sameSet,
  output logic              snpShared,
  output logic              snpFlush
);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int SETS  = 1 << SET_W;

  lineState_t       stQ  [SETS];
  logic [TAG_W-1:0] tagQ [SETS];

  logic [SET_W-1:0] cpuSet, snpSet;
  logic [TAG_W-1:0] cpuTag, snpTag;
  lineState_t       snpSt, snpNext;
  logic             snpHit, snpWr;

  assign cpuSet = cpuAddr[SET_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:SET_W];
  assign snpSet = snpAddr[SET_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:SET_W];

  assign cpuSt   = stQ[cpuSet];
  assign cpuTagQ = tagQ[cpuSet];
  assign cpuHit  = (cpuSt != ST_I) && (cpuTagQ == cpuTag);
  assign sameSet = snpValid && (snpSet == cpuSet);

  assign snpSt  = stQ[snpSet];
  assign snpHit = snpValid && (snpSt != ST_I) && (tagQ[snpSet] == snpTag);

  // snoop-side next state
  always_comb begin
    snpWr     = 1'b0;
    snpNext   = snpSt;
    snpShared = 1'b0;
    snpFlush  = 1'b0;
    if (snpHit) begin
      case (snpCmd)
        SNP_RD: begin
          snpShared = 1'b1;
          snpFlush  = (snpSt == ST_M);
          if (snpSt != ST_S) begin
            snpWr   = 1'b1;
            snpNext = ST_S;
          end
        end
        SNP_RDX: begin
          snpFlush = (snpSt == ST_M);
          snpWr    = 1'b1;
          snpNext  = ST_I;
        end
        SNP_INV: begin
          snpWr   = 1'b1;
          snpNext = ST_I;
        end
        default: ;
      endcase
    end
  end

  // per-set storage; a snoop update wins over a processor-side write
  for (genvar g = 0; g < SETS; g++) begin : gSet
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ[g]  <= ST_I;
        tagQ[g] <= '0;
      end else if (snpWr && (snpSet == SET_W'(g))) begin
        stQ[g] <= snpNext;
      end else if ((cpuSet == SET_W'(g)) && (strb.fillEn || strb.dropEn)) begin
        stQ[g] <= strb.fillEn ? strb.fillState : ST_I;
        if (strb.fillEn) tagQ[g] <= cpuTag;
      end
    end
  end

  // R8
  snp_rd_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpHit && snpCmd == SNP_RD && snpSt == ST_M) |=> stQ[$past(snpSet)] == ST_S);

  // R9
  snp_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpHit && (snpCmd == SNP_RDX || snpCmd == SNP_INV)) |=> stQ[$past(snpSet)] == ST_I);

  // R8
  shared_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpShared |-> (snpValid && snpCmd == SNP_RD && snpSt != ST_I));

  // R11
  snp_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpCmd == 2'd3) |=> stQ[$past(snpSet)] == $past(snpSt));
endmodule

// File: rtl/coh_access_ctrl.sv
`timescale 1ns/1ps
module coh_access_ctrl
  import coh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuValid,
  input  logic        cpuWrite,
  input  logic        cpuHit,
  input  lineState_t  cpuSt,
  input  logic        sameSet,
  input  logic        busAck,
  input  logic        busShared,
  output ctrlStrobe_t strb,
  output logic        cpuDone,
  output logic        busReqValid,
  output busCmd_t     busCmd,
  output logic        useVictim
);
  logic quickHit, needUpgr, dirtyVictim;

  assign quickHit    = cpuHit && (!cpuWrite || cpuSt != ST_S);
  assign needUpgr    = cpuHit && cpuWrite && (cpuSt == ST_S);
  assign dirtyVictim = !cpuHit && (cpuSt == ST_M);

  // request chosen from the present line state every cycle
  always_comb begin
    strb        = '{fillEn: 1'b0, fillState: ST_I, dropEn: 1'b0};
    cpuDone     = 1'b0;
    busReqValid = 1'b0;
    busCmd      = BUS_RD;
    useVictim   = 1'b0;
    if (cpuValid && !sameSet) begin
      if (quickHit) begin
        cpuDone = 1'b1;
        if (cpuWrite && cpuSt == ST_E) begin
          strb.fillEn    = 1'b1;
          strb.fillState = ST_M;
        end
      end else if (needUpgr) begin
        busReqValid = 1'b1;
        busCmd      = BUS_UPGR;
        if (busAck) begin
          strb.fillEn    = 1'b1;
          strb.fillState = ST_M;
          cpuDone        = 1'b1;
        end
      end else if (dirtyVictim) begin
        busReqValid = 1'b1;
        busCmd      = BUS_WB;
        useVictim   = 1'b1;
        if (busAck) strb.dropEn = 1'b1;
      end else begin
        busReqValid = 1'b1;
        busCmd      = cpuWrite ? BUS_RDX : BUS_RD;
        if (busAck) begin
          strb.fillEn    = 1'b1;
          strb.fillState = cpuWrite ? ST_M : (busShared ? ST_S : ST_E);
          cpuDone        = 1'b1;
        end
      end
    end
  end

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> (!busReqValid || busAck));

  // R10
  same_set_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && sameSet) |-> (!cpuDone && !busReqValid));

  // R7
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && busCmd == BUS_WB && busAck && cpuValid) |-> !cpuDone);

  // R4
  upgr_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && busCmd == BUS_UPGR) |-> (cpuHit && cpuSt == ST_S));
endmodule

// File: rtl/coh_ctrl_top.sv
`timescale 1ns/1ps
module coh_ctrl_top
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SET_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuHit,
  output logic              cpuDone,
  output logic              busReqValid,
  output logic [1:0]        busReqCmd,
  output logic [ADDR_W-1:0] busReqAddr,
  input  logic              busAck,
  input  logic              busShared,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpShared,
  output logic              snpFlush
);
  localparam int TAG_W = ADDR_W - SET_W;

  ctrlStrobe_t      strb;
  lineState_t       cpuSt;
  logic [TAG_W-1:0] cpuTagQ;
  logic             sameSet, useVictim;
  busCmd_t          busCmd;

  coh_line_store #(.ADDR_W(ADDR_W), .SET_W(SET_W)) uStore (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .strb(strb),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .cpuSt(cpuSt), .cpuTagQ(cpuTagQ), .cpuHit(cpuHit), .sameSet(sameSet),
    .snpShared(snpShared), .snpFlush(snpFlush)
  );

  coh_access_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuHit(cpuHit), .cpuSt(cpuSt), .sameSet(sameSet),
    .busAck(busAck), .busShared(busShared), .strb(strb),
    .cpuDone(cpuDone), .busReqValid(busReqValid), .busCmd(busCmd),
    .useVictim(useVictim)
  );

  assign busReqCmd  = busCmd;
  assign busReqAddr = useVictim ? {cpuTagQ, cpuAddr[SET_W-1:0]} : cpuAddr;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !snpShared && !snpFlush && !cpuHit);
endmodule

// File: tb/coh_ctrl_top_test.sv
`timescale 1ns/1ps
module coh_ctrl_top_test;
  import coh_pkg::*;
  localparam int ADDR_W = 16;
  localparam int SET_W  = 4;
  localparam int TAG_W  = ADDR_W - SET_W;
  localparam int SETS   = 1 << SET_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpuValid = 0, cpuWrite = 0;
  logic [ADDR_W-1:0] cpuAddr = '0, snpAddr = '0;
  logic busAck = 0, busShared = 0, snpValid = 0;
  logic [1:0] snpCmd = 2'd3;
  logic cpuHit, cpuDone, busReqValid, snpShared, snpFlush;
  logic [1:0] busReqCmd;
  logic [ADDR_W-1:0] busReqAddr;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [1:0]       mSt  [SETS];
  logic [TAG_W-1:0] mTag [SETS];

  always #4 clk = ~clk; // 125 MHz

  coh_ctrl_top #(.ADDR_W(ADDR_W), .SET_W(SET_W)) uut (.*);

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [1:0] fillState(input bit wr, input bit sh);
    return wr ? ST_M : (sh ? ST_S : ST_E);
  endfunction

  function automatic bit modelHit(input logic [ADDR_W-1:0] a);
    return mSt[a[SET_W-1:0]] != ST_I && mTag[a[SET_W-1:0]] == a[ADDR_W-1:SET_W];
  endfunction

  task automatic nextCycle();
    @(posedge clk); #1;
  endtask

  // wait cycles then acknowledge one bus request
  task automatic busPhase(input logic [1:0] cmd, input logic [ADDR_W-1:0] a,
                          input bit sh, input bit lastDone, input string rq);
    int waits = $urandom % 3;
    for (int w = 0; w < waits; w++) begin
      #5;
      chk(busReqValid && busReqCmd == cmd && busReqAddr == a && !cpuDone, rq, "pending request",
          {13'd0, busReqValid, busReqCmd, busReqAddr}, {13'd0, 1'b1, cmd, a});
      nextCycle();
    end
    busAck = 1; busShared = sh;
    #5;
    chk(busReqValid && busReqCmd == cmd && busReqAddr == a && cpuDone == lastDone, rq,
        "ack cycle", {12'd0, cpuDone, busReqValid, busReqCmd, busReqAddr},
        {12'd0, lastDone, 1'b1, cmd, a});
    nextCycle();
    busAck = 0; busShared = 0;
  endtask

  task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input int shSel);
    int s = int'(a[SET_W-1:0]);
    bit hit = modelHit(a);
    bit sh = (shSel < 0) ? bit'($urandom % 2) : bit'(shSel);
    cpuValid = 1; cpuWrite = wr; cpuAddr = a;
    if (hit && (!wr || mSt[s] != ST_S)) begin
      #5;
      chk(cpuDone && cpuHit && !busReqValid, wr ? (mSt[s] == ST_E ? "R5" : "R6") : "R6",
          "hit completes quietly", {29'd0, cpuDone, cpuHit, busReqValid}, 32'd6);
      nextCycle();
      if (wr) mSt[s] = ST_M;
    end else if (hit) begin
      busPhase(BUS_UPGR, a, 0, 1, "R4");
      mSt[s] = ST_M;
    end else begin
      if (mSt[s] == ST_M) begin
        busPhase(BUS_WB, {mTag[s], a[SET_W-1:0]}, 0, 0, "R7");
        mSt[s] = ST_I;
      end
      busPhase(wr ? BUS_RDX : BUS_RD, a, sh, 1, wr ? "R3" : "R2");
      mTag[s] = a[ADDR_W-1:SET_W];
      mSt[s]  = fillState(wr, sh);
    end
    cpuValid = 0;
  endtask

  // apply one snoop to the model, return expected responses
  task automatic modelSnoop(input logic [1:0] cmd, input logic [ADDR_W-1:0] a,
                            output bit expSh, output bit expFl);
    int s = int'(a[SET_W-1:0]);
    bit hit = modelHit(a);
    expSh = hit && cmd == SNP_RD;
    expFl = hit && mSt[s] == ST_M && (cmd == SNP_RD || cmd == SNP_RDX);
    if (hit) begin
      if (cmd == SNP_RD && mSt[s] != ST_S) mSt[s] = ST_S;
      else if (cmd == SNP_RDX || cmd == SNP_INV) mSt[s] = ST_I;
    end
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [ADDR_W-1:0] a);
    bit eSh, eFl;
    string rq = (cmd == SNP_RD) ? "R8" : (cmd == 2'd3 ? "R11" : "R9");
    if (!modelHit(a)) rq = "R11";
    snpValid = 1; snpCmd = cmd; snpAddr = a;
    modelSnoop(cmd, a, eSh, eFl);
    #5;
    chk(snpShared == eSh && snpFlush == eFl, rq, "snoop response",
        {30'd0, snpShared, snpFlush}, {30'd0, eSh, eFl});
    nextCycle();
    snpValid = 0; snpCmd = 2'd3;
  endtask

  initial begin
    #1200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < SETS; i++) begin mSt[i] = ST_I; mTag[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    nextCycle();
    // R1: quiet after reset, first access misses
    #5;
    chk(!busReqValid && !cpuDone && !snpShared && !snpFlush, "R1", "idle outputs",
        {28'd0, busReqValid, cpuDone, snpShared, snpFlush}, 32'd0);
    nextCycle();
    cpuValid = 1; cpuWrite = 0; cpuAddr = 16'h0123;
    #5;
    chk(!cpuHit && busReqValid && busReqCmd == BUS_RD, "R1", "first access misses",
        {29'd0, cpuHit, busReqValid, busReqCmd == BUS_RD}, 32'd3);
    nextCycle();
    // directed walk through the states
    access(0, 16'h0123, 0);        // R2 -> E
    access(1, 16'h0123, -1);       // R5 -> M silently
    snoop(SNP_RD, 16'h0123);       // R8 flush, -> S
    access(0, 16'h0123, -1);       // R6 read hit S
    access(1, 16'h0123, -1);       // R4 upgrade -> M
    access(1, 16'h0123, -1);       // R6 write hit M
    access(1, 16'h4563, -1);       // R7 write-back then R3
    snoop(SNP_RDX, 16'h4563);      // R9 flush, -> I
    access(0, 16'h0777, 1);        // R2 -> S
    snoop(2'd3, 16'h0777);         // R11 no effect
    snoop(SNP_RD, 16'h0887);       // R11 tag miss
    access(0, 16'h0777, -1);       // still a hit
    // R10: access and snoop on the same set in one cycle
    cpuValid = 1; cpuWrite = 1; cpuAddr = 16'h0777;
    snpValid = 1; snpCmd = SNP_RD; snpAddr = 16'h0777;
    begin
      bit eSh, eFl;
      modelSnoop(SNP_RD, 16'h0777, eSh, eFl);
      #5;
      chk(!cpuDone && !busReqValid && snpShared == eSh, "R10", "stall on same set",
          {29'd0, cpuDone, busReqValid, snpShared}, {29'd0, 1'b0, 1'b0, eSh});
      nextCycle();
    end
    snpValid = 0; snpCmd = 2'd3;
    // R4: upgrade raised, invalidated before the ack, becomes read-for-ownership
    #5;
    chk(busReqValid && busReqCmd == BUS_UPGR, "R4", "upgrade raised",
        {30'd0, busReqCmd}, {30'd0, BUS_UPGR});
    nextCycle();
    snpValid = 1; snpCmd = SNP_INV; snpAddr = 16'h0777;
    #5;
    chk(!busReqValid && !cpuDone, "R10", "stall under invalidate",
        {30'd0, busReqValid, cpuDone}, 32'd0);
    nextCycle();
    snpValid = 0; snpCmd = 2'd3;
    mSt[7] = ST_I;
    busPhase(BUS_RDX, 16'h0777, 0, 1, "R4");
    mSt[7] = ST_M;
    cpuValid = 0;
    snoop(SNP_INV, 16'h0777);      // R9 plain invalidate, no flush
    // random mix
    for (int n = 0; n < 700; n++) begin
      logic [ADDR_W-1:0] a = {TAG_W'($urandom % 4), SET_W'($urandom % 4)};
      if ($urandom % 10 < 7) access(bit'($urandom % 2), a, -1);
      else snoop(2'($urandom % 4), a);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule